// File: doc/BRIEF.md
# Ethernet Frame to Word Stream Unpacker

This block sits behind a MAC receive path whose frame check sequence has already been verified and removed. It sees each frame as a byte stream with a valid strobe and an end-of-frame flag. It keeps a frame only when three header fields match compile-time parameters: the destination address must equal the local station address, the source address must equal the single expected peer, and the type field must equal a private protocol value. A frame that fails any of these checks produces nothing.

After the 14-byte address and type header comes a 2-byte big-endian length field, then the payload. A nonzero length gives the number of meaningful payload bytes, and the bytes after that count are padding that was added to reach the minimum frame size. A length of zero means every payload byte up to the end of the frame is meaningful. The block packs the meaningful bytes into 32-bit words and writes each word once into a downstream FIFO through a write strobe and a full indication. It has no back-pressure toward the sender. A word that meets a full FIFO is lost and counted. A tail shorter than a word is lost and counted.

Top module: `fsu_frame_unpack`

## Requirements
- R1: A frame whose first six bytes differ in any bit from LOCAL_MAC (most significant byte first) produces no output word and changes neither counter.
- R2: A frame whose bytes 6 to 11 differ from PEER_MAC (most significant byte first) produces no output word and changes neither counter.
- R3: A frame whose bytes 12 and 13 differ from ETHERTYPE (high byte first) produces no output word and changes neither counter.
- R4: Bytes 14 and 15 form a big-endian length L. When L is nonzero, only the first min(L, P) payload bytes are used, where P is the number of bytes from byte 16 to the end of the frame. The remaining bytes are discarded.
- R5: When L is zero, all P payload bytes are used.
- R6: Used bytes are packed four at a time, with the earliest byte in bits 31:24. out_valid is high for exactly one cycle, in the cycle after the clock edge that accepts the fourth byte of a word. The word is on out_data during that cycle.
- R7: When a kept frame ends with 1 to 3 used bytes not yet packed into a word, those bytes are dropped and partial_count increments by one.
- R8: If out_full is high at the edge that accepts the fourth byte of a word, that word is not written and ovf_count increments by one.
- R9: A frame whose end flag arrives on any of bytes 0 to 15 produces no word and changes neither counter.
- R10: After reset, out_valid is low and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| rx_last | input | 1 | The current byte is the final byte of the frame |
| out_full | input | 1 | Downstream FIFO cannot take a word |
| out_valid | output | 1 | Write strobe for out_data |
| out_data | output | 32 | Packed word, earliest byte in the high bits |
| ovf_count | output | CNT_W | Words lost to a full FIFO, wraps |
| partial_count | output | CNT_W | Frames that ended with a partial word, wraps |

## Verification
The hardest cases to reach from the ports lie where trimming, packing and frame end meet. One case is a length field that is larger than the real payload. Another is a trimmed count that ends inside a word while padding bytes still follow. A third is a frame cut off inside its own length field. The stimulus sweeps every payload size from 0 to 13 bytes against every length value from 0 to two more than that size, with idle gaps inserted between bytes on alternate frames. It also corrupts each header byte position in turn, and ends frames at each of the first sixteen byte positions. Holding the full input high for a whole frame shows the overflow path without needing a real FIFO.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int MATCH_LAST = 13;
    localparam int LEN_HI_POS = 14;
    localparam int LEN_LO_POS = 15;
    localparam int DATA_POS   = 16;
    localparam int POS_W      = 5;
    localparam int LEN_W      = 16;

    typedef enum logic [1:0] {
        SEG_MATCH,
        SEG_LEN_HI,
        SEG_LEN_LO,
        SEG_DATA
    } seg_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              last;
    } rx_beat_t;

    function automatic seg_e seg_of(input logic [POS_W-1:0] pos);
        if (int'(pos) <= MATCH_LAST)      return SEG_MATCH;
        else if (int'(pos) == LEN_HI_POS) return SEG_LEN_HI;
        else if (int'(pos) == LEN_LO_POS) return SEG_LEN_LO;
        else                              return SEG_DATA;
    endfunction

    // Expected header byte at position pos (0..13), address/type order on the wire
    function automatic logic [BYTE_W-1:0] hdr_byte(
        input logic [POS_W-1:0] pos,
        input logic [47:0]      dst,
        input logic [47:0]      src,
        input logic [15:0]      etype
    );
        logic [111:0] h;
        int           sh;
        h  = {dst, src, etype};
        sh = (int'(pos) <= MATCH_LAST) ? (MATCH_LAST - int'(pos)) * BYTE_W : 0;
        return h[sh +: BYTE_W];
    endfunction

endpackage

// File: rtl/fsu_hdr_filter.sv
module fsu_hdr_filter
    import fsu_pkg::*;
#(
    parameter logic [47:0] LOCAL_MAC = 48'h02_00_00_00_00_01,
    parameter logic [47:0] PEER_MAC  = 48'h02_00_00_00_00_02,
    parameter logic [15:0] ETHERTYPE = 16'h88B5
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_beat_t          beat,
    output logic              pay_valid,
    output logic [BYTE_W-1:0] pay_data,
    output logic              frame_end
);

    logic [POS_W-1:0] pos_q;
    logic             reject_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] seen_q;
    seg_e             seg;
    logic             hit;

    always_comb begin
        seg       = seg_of(pos_q);
        hit       = (beat.data == hdr_byte(pos_q, LOCAL_MAC, PEER_MAC, ETHERTYPE));
        frame_end = beat.valid && beat.last;
        pay_data  = beat.data;
        pay_valid = beat.valid && (seg == SEG_DATA) && !reject_q &&
                    ((len_q == '0) || (seen_q < len_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            reject_q <= 1'b0;
            len_q    <= '0;
            seen_q   <= '0;
        end else if (beat.valid) begin
            if (beat.last) begin
                pos_q    <= '0;
                reject_q <= 1'b0;
                len_q    <= '0;
                seen_q   <= '0;
            end else begin
                unique case (seg)
                    SEG_MATCH: begin
                        if (!hit) reject_q <= 1'b1;
                        pos_q <= pos_q + 1'b1;
                    end
                    SEG_LEN_HI: begin
                        len_q[15:8] <= beat.data;
                        pos_q       <= pos_q + 1'b1;
                    end
                    SEG_LEN_LO: begin
                        len_q[7:0] <= beat.data;
                        pos_q      <= pos_q + 1'b1;
                    end
                    SEG_DATA: begin
                        if (seen_q != '1) seen_q <= seen_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1 R2 R3: once a header byte mismatches, the frame stays rejected until its end
    a_r3_reject_holds: assert property (@(posedge clk) disable iff (rst)
        (reject_q && !frame_end) |=> reject_q);

    // R9: no payload byte is released while the length field is incomplete
    a_r9_no_data_early: assert property (@(posedge clk) disable iff (rst)
        (pos_q < POS_W'(DATA_POS)) |-> !pay_valid);

endmodule

// File: rtl/fsu_word_pack.sv
module fsu_word_pack
    import fsu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pay_valid,
    input  logic [BYTE_W-1:0] pay_data,
    input  logic              frame_end,
    input  logic              out_full,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic [CNT_W-1:0]  ovf_count,
    output logic [CNT_W-1:0]  partial_count
);

    localparam int ACC_W = WORD_W - BYTE_W;

    logic [1:0]       fill_q;
    logic [1:0]       fill_nxt;
    logic [ACC_W-1:0] acc_q;
    logic             word_done;

    always_comb begin
        word_done = pay_valid && (fill_q == 2'd3);
        fill_nxt  = pay_valid ? fill_q + 2'd1 : fill_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q        <= '0;
            acc_q         <= '0;
            out_valid     <= 1'b0;
            out_data      <= '0;
            ovf_count     <= '0;
            partial_count <= '0;
        end else begin
            out_valid <= 1'b0;
            if (pay_valid) begin
                acc_q <= {acc_q[ACC_W-BYTE_W-1:0], pay_data};
                if (word_done) begin
                    if (!out_full) begin
                        out_valid <= 1'b1;
                        out_data  <= {acc_q, pay_data};
                    end else begin
                        ovf_count <= ovf_count + 1'b1;
                    end
                end
            end
            if (frame_end) begin
                fill_q <= '0;
                if (fill_nxt != 2'd0) partial_count <= partial_count + 1'b1;
            end else begin
                fill_q <= fill_nxt;
            end
        end
    end

    // R6: a word strobe never repeats in back-to-back cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: a word is only written when the FIFO had room at the accepting edge
    a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(out_full));

    // R8: the loss counter moves only after a full indication
    a_r8_ovf_needs_full: assert property (@(posedge clk) disable iff (rst)
        (ovf_count != $past(ovf_count)) |-> $past(out_full));

    // R7: the partial-word counter moves only at a frame end
    a_r7_partial_at_end: assert property (@(posedge clk) disable iff (rst)
        (partial_count != $past(partial_count)) |-> $past(frame_end));

endmodule

// File: rtl/fsu_frame_unpack.sv
module fsu_frame_unpack
    import fsu_pkg::*;
#(
    parameter logic [47:0] LOCAL_MAC = 48'h02_00_00_00_00_01,
    parameter logic [47:0] PEER_MAC  = 48'h02_00_00_00_00_02,
    parameter logic [15:0] ETHERTYPE = 16'h88B5,
    parameter int          CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    input  logic             rx_last,
    input  logic             out_full,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic [CNT_W-1:0] ovf_count,
    output logic [CNT_W-1:0] partial_count
);

    rx_beat_t          beat;
    logic              pay_valid;
    logic [BYTE_W-1:0] pay_data;
    logic              frame_end;

    always_comb begin
        beat.data  = rx_data;
        beat.valid = rx_valid;
        beat.last  = rx_last;
    end

    fsu_hdr_filter #(
        .LOCAL_MAC (LOCAL_MAC),
        .PEER_MAC  (PEER_MAC),
        .ETHERTYPE (ETHERTYPE)
    ) u_filter (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .pay_valid (pay_valid),
        .pay_data  (pay_data),
        .frame_end (frame_end)
    );

    fsu_word_pack #(
        .CNT_W (CNT_W)
    ) u_pack (
        .clk           (clk),
        .rst           (rst),
        .pay_valid     (pay_valid),
        .pay_data      (pay_data),
        .frame_end     (frame_end),
        .out_full      (out_full),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .ovf_count     (ovf_count),
        .partial_count (partial_count)
    );

    // R6: a word appears only after a byte was accepted on the previous edge
    a_r6_word_follows_byte: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(rx_valid));

endmodule

// File: tb/tb_fsu_frame_unpack.sv
module tb_fsu_frame_unpack;

    localparam logic [47:0] LMAC  = 48'h02_1A_2B_3C_4D_01;
    localparam logic [47:0] PMAC  = 48'h02_1A_2B_3C_4D_02;
    localparam logic [15:0] ETYP  = 16'h88B5;
    localparam int          CW    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    rx_data = '0;
    logic          rx_valid = 1'b0;
    logic          rx_last = 1'b0;
    logic          out_full = 1'b0;
    logic          out_valid;
    logic [31:0]   out_data;
    logic [CW-1:0] ovf_count;
    logic [CW-1:0] partial_count;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;
    logic [31:0] got[$];
    logic [7:0]  fr[$];

    always #2.5 clk = ~clk;

    fsu_frame_unpack #(
        .LOCAL_MAC (LMAC),
        .PEER_MAC  (PMAC),
        .ETHERTYPE (ETYP),
        .CNT_W     (CW)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_last       (rx_last),
        .out_full      (out_full),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .ovf_count     (ovf_count),
        .partial_count (partial_count)
    );

    always @(negedge clk) if (!rst && out_valid) got.push_back(out_data);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            vectors = vectors + 1;
            $display("FAIL R10 watchdog: actual %0d cycles expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int seed, input int j);
        return 8'((seed * 13 + j * 29 + 5) & 8'hFF);
    endfunction

    // Build a frame: payload plen bytes, length field lhdr, byte bad_pos flipped, cut to cut bytes
    task automatic build(input int plen, input int lhdr, input int bad_pos,
                         input int cut, input int seed);
        logic [111:0] h;
        h = {LMAC, PMAC, ETYP};
        fr.delete();
        for (int i = 0; i < 14; i++) fr.push_back(h[(13 - i) * 8 +: 8]);
        fr.push_back(8'(lhdr >> 8));
        fr.push_back(8'(lhdr));
        for (int j = 0; j < plen; j++) fr.push_back(pbyte(seed, j));
        if (bad_pos >= 0) fr[bad_pos] = fr[bad_pos] ^ 8'h40;
        if (cut > 0) while (fr.size() > cut) void'(fr.pop_back());
    endtask

    task automatic send(input bit gaps, input bit full);
        got.delete();
        @(negedge clk);
        out_full = full;
        for (int i = 0; i < fr.size(); i++) begin
            if (gaps && (i % 5 == 3)) begin
                rx_valid = 1'b0;
                rx_data  = 8'hA5;
                rx_last  = 1'b1;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_data  = fr[i];
            rx_last  = (i == fr.size() - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        repeat (3) @(negedge clk);
        out_full = 1'b0;
    endtask

    // Send a frame and compare words and counter deltas against arithmetic expectation
    task automatic run(input int plen, input int lhdr, input int bad_pos, input int cut,
                       input bit gaps, input bit full, input string req);
        int used, nw, exp_words, seed;
        logic [CW-1:0] ovf0, par0;
        bit kept;
        seed = plen * 7 + lhdr + 3;
        build(plen, lhdr, bad_pos, cut, seed);
        kept = (bad_pos < 0) && (cut <= 0);
        used = (lhdr == 0 || lhdr > plen) ? plen : lhdr;
        if (!kept) used = 0;
        nw = used / 4;
        exp_words = full ? 0 : nw;
        ovf0 = ovf_count;
        par0 = partial_count;
        send(gaps, full);
        check(got.size() == exp_words, req, "word count", got.size(), exp_words);
        for (int k = 0; k < got.size() && k < exp_words; k++) begin
            logic [31:0] e;
            e = {pbyte(seed, 4*k), pbyte(seed, 4*k+1), pbyte(seed, 4*k+2), pbyte(seed, 4*k+3)};
            check(got[k] == e, "R6", "packed word", got[k], e);
        end
        check(CW'(partial_count - par0) == CW'((used % 4) != 0), "R7", "partial delta",
              partial_count - par0, (used % 4) != 0);
        check(CW'(ovf_count - ovf0) == CW'(full ? nw : 0), "R8", "overflow delta",
              ovf_count - ovf0, full ? nw : 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        check(ovf_count == '0, "R10", "ovf_count after reset", ovf_count, 0);
        check(partial_count == '0, "R10", "partial_count after reset", partial_count, 0);

        // R4 R5 sweep of payload sizes against length values, gaps on alternate frames
        for (int p = 0; p <= 13; p++)
            for (int l = 0; l <= p + 2; l++)
                run(p, l, -1, 0, ((p + l) % 2) == 1, 1'b0, (l == 0) ? "R5" : "R4");
        run(6, 300, -1, 0, 1'b0, 1'b0, "R4");

        // R1 R2 R3 header mismatch at every header position
        for (int b = 0; b < 14; b++)
            run(8, 0, b, 0, 1'b0, 1'b0, (b < 6) ? "R1" : (b < 12) ? "R2" : "R3");

        // R9 frames ending at positions 0..15
        for (int c = 1; c <= 16; c++)
            run(8, 0, -1, c, 1'b0, 1'b0, "R9");

        // R8 overflow with the FIFO held full
        run(8, 0, -1, 0, 1'b0, 1'b1, "R8");
        run(11, 10, -1, 0, 1'b1, 1'b1, "R8");
        run(12, 0, -1, 0, 1'b0, 1'b0, "R6");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule